// File: doc/BRIEF.md
# Strict SPECIAL-Class Retire Decoder

This block is a simplified, single-issue execute stub for a MIPS-style core. Each cycle it may accept one fetched 32-bit instruction word together with the address it was fetched from. It decodes the word and retires it. Retiring means it updates the general registers or the HI/LO pair, reports the address of the retired slot, and presents the address of the next instruction. The block has no pipeline. Every accepted instruction is finished and reported one clock after it is presented.

The block covers the register-to-register group that sits under primary opcode zero: shifts, arithmetic and logic, HI/LO moves and multiplies, register jumps, the service call and the memory barrier. It also covers the two immediate loads that are needed to build constants, LUI and ORI. Instructions it does not recognise are handled according to a mode input. In strict mode they raise a sticky trap that records the address and the word. In relaxed mode they retire as no-ops. Recognised no-ops are taken only from an exact allow-list, so an unused function code next to the barrier is never absorbed by accident.

A harness uses the retire address to confirm that a given slot has retired. It uses the trap outputs to find the first instruction the stub cannot yet execute.

Top module: `sretire_core`

## Requirements
- R1: After reset, retire_o and trap_o are 0, retire_cnt_o is 0, all general registers read 0, and hi_o and lo_o are 0.
- R2: A word with bits[31:26]=0 and function bits[5:0]=0x0F (barrier) retires. next_pc_o becomes pc+4. No general register, HI or LO changes.
- R3: R-type operations with bits[31:26]=0 write rd (bits[15:11]) as follows. Funct 0x00, 0x02 and 0x03 shift rt (bits[20:16]) left, right logical or right arithmetic by bits[10:6]. Funct 0x04, 0x06 and 0x07 are the same shifts by rs[4:0], where rs is bits[25:21]. Funct 0x20 and 0x21 add without overflow trap. Funct 0x22 and 0x23 subtract. Funct 0x24 is AND, 0x25 is OR, 0x26 is XOR and 0x27 is NOR. Funct 0x2A is set-less-than signed and 0x2B is set-less-than unsigned. All of these go to pc+4.
- R4: Primary opcode 0x0F (LUI) writes rt with {imm,16'h0}. Primary opcode 0x0D (ORI) writes rt with rs OR the zero-extended imm, where imm is bits[15:0]. Both work normally right after a barrier.
- R5: HI/LO group, all with bits[31:26]=0. Funct 0x18 writes the signed 64-bit product of rs and rt to {HI,LO}. Funct 0x19 writes the unsigned product. Funct 0x10 copies HI to rd and 0x12 copies LO to rd. Funct 0x11 writes rs to HI and 0x13 writes rs to LO.
- R6: Funct 0x08 sets next_pc_o to the value of rs. Funct 0x09 also does this and writes pc+8 to rd.
- R7: Funct 0x0C (service call) writes 0 to register 2 and advances to pc+4.
- R8: With strict_i=1, an unrecognised word raises trap_o. This covers any other SPECIAL funct, such as word 0x0000000E, and any other primary opcode. trap_pc_o and trap_instr_o capture the pc and the word. The word does not retire and changes no state.
- R9: With strict_i=0, an unrecognised word retires as a no-op to pc+4 with no register or HI/LO change.
- R10: Once trap_o is set it stays set until reset. While it is set, valid_i is ignored and nothing retires.
- R11: Writes to register 0 are discarded, and register 0 always reads 0.
- R12: Each accepted instruction produces exactly one one-cycle retire_o pulse in the cycle after it is presented. retire_pc_o holds its pc and retire_cnt_o increments by one per pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| strict_i | input | 1 | 1: unrecognised words trap; 0: they retire as no-ops |
| valid_i | input | 1 | An instruction is presented this cycle |
| instr_i | input | 32 | Instruction word |
| pc_i | input | 32 | Address of instr_i |
| dbg_addr_i | input | 5 | General register read select |
| dbg_data_o | output | 32 | Value of the selected register |
| hi_o | output | 32 | HI register |
| lo_o | output | 32 | LO register |
| retire_o | output | 1 | One-cycle retire pulse |
| retire_pc_o | output | 32 | PC of the last retired instruction |
| next_pc_o | output | 32 | Next PC after the last retired instruction |
| retire_cnt_o | output | CNT_W | Count of retired instructions |
| trap_o | output | 1 | Sticky trap flag |
| trap_pc_o | output | 32 | PC of the trapping word |
| trap_instr_o | output | 32 | Trapping instruction word |

## Verification
The hardest case to reach is an unused function code that sits beside a recognised one, arriving after a long run of legal traffic in strict mode. This case decides whether the allow-list is narrow, and random traffic over legal codes never produces it. The bench therefore first fills the registers through LUI/ORI and runs constrained-random legal instructions. It then presents word 0x0000000E in relaxed mode, where it must retire with no effect, and again in strict mode, where it must trap. After the trap, a barrier is offered and must be ignored. After every instruction, all 32 registers and HI/LO are swept through the read port, so a barrier or no-op that leaks a write is caught.

// File: rtl/sretire_pkg.sv
package sretire_pkg;
  localparam int XLEN   = 32;
  localparam int NREG   = 32;
  localparam int RIDX_W = $clog2(NREG);

  localparam logic [5:0] OP_SPECIAL = 6'h00;
  localparam logic [5:0] OP_ORI     = 6'h0D;
  localparam logic [5:0] OP_LUI     = 6'h0F;

  localparam logic [5:0] FN_SLL  = 6'h00, FN_SRL  = 6'h02, FN_SRA  = 6'h03;
  localparam logic [5:0] FN_SLLV = 6'h04, FN_SRLV = 6'h06, FN_SRAV = 6'h07;
  localparam logic [5:0] FN_JR   = 6'h08, FN_JALR = 6'h09, FN_SYSC = 6'h0C;
  localparam logic [5:0] FN_SYNC = 6'h0F;
  localparam logic [5:0] FN_MFHI = 6'h10, FN_MTHI = 6'h11, FN_MFLO = 6'h12, FN_MTLO = 6'h13;
  localparam logic [5:0] FN_MULT = 6'h18, FN_MULTU = 6'h19;
  localparam logic [5:0] FN_ADD  = 6'h20, FN_ADDU = 6'h21, FN_SUB = 6'h22, FN_SUBU = 6'h23;
  localparam logic [5:0] FN_AND  = 6'h24, FN_OR   = 6'h25, FN_XOR = 6'h26, FN_NOR  = 6'h27;
  localparam logic [5:0] FN_SLT  = 6'h2A, FN_SLTU = 6'h2B;

  localparam logic [RIDX_W-1:0] SVC_RET_REG = RIDX_W'(2);

  typedef enum logic [3:0] {
    K_NOP, K_BAD, K_ALU, K_LUI, K_ORI, K_JR, K_JALR, K_SVC, K_SYNC,
    K_MFHI, K_MTHI, K_MFLO, K_MTLO, K_MULT, K_MULTU
  } kind_e;

  typedef enum logic [3:0] {
    A_SLL, A_SRL, A_SRA, A_ADD, A_SUB, A_AND, A_OR, A_XOR, A_NOR, A_SLT, A_SLTU
  } alu_e;

  typedef struct packed {
    kind_e kind;
    alu_e  alu;
    logic  var_shift;
  } dec_t;
endpackage

// File: rtl/sretire_decode.sv
module sretire_decode
  import sretire_pkg::*;
(
  input  logic [5:0] op_i,
  input  logic [5:0] fn_i,
  output dec_t       dec_o
);
  always_comb begin
    dec_o = '{kind: K_BAD, alu: A_ADD, var_shift: 1'b0};
    if (op_i == OP_LUI) begin
      dec_o.kind = K_LUI;
    end else if (op_i == OP_ORI) begin
      dec_o.kind = K_ORI;
    end else if (op_i == OP_SPECIAL) begin
      unique case (fn_i)
        FN_SLL:  begin dec_o.kind = K_ALU; dec_o.alu = A_SLL; end
        FN_SRL:  begin dec_o.kind = K_ALU; dec_o.alu = A_SRL; end
        FN_SRA:  begin dec_o.kind = K_ALU; dec_o.alu = A_SRA; end
        FN_SLLV: begin dec_o.kind = K_ALU; dec_o.alu = A_SLL; dec_o.var_shift = 1'b1; end
        FN_SRLV: begin dec_o.kind = K_ALU; dec_o.alu = A_SRL; dec_o.var_shift = 1'b1; end
        FN_SRAV: begin dec_o.kind = K_ALU; dec_o.alu = A_SRA; dec_o.var_shift = 1'b1; end
        FN_JR:    dec_o.kind = K_JR;
        FN_JALR:  dec_o.kind = K_JALR;
        FN_SYSC:  dec_o.kind = K_SVC;
        FN_SYNC:  dec_o.kind = K_SYNC;
        FN_MFHI:  dec_o.kind = K_MFHI;
        FN_MTHI:  dec_o.kind = K_MTHI;
        FN_MFLO:  dec_o.kind = K_MFLO;
        FN_MTLO:  dec_o.kind = K_MTLO;
        FN_MULT:  dec_o.kind = K_MULT;
        FN_MULTU: dec_o.kind = K_MULTU;
        FN_ADD, FN_ADDU: begin dec_o.kind = K_ALU; dec_o.alu = A_ADD; end
        FN_SUB, FN_SUBU: begin dec_o.kind = K_ALU; dec_o.alu = A_SUB; end
        FN_AND:  begin dec_o.kind = K_ALU; dec_o.alu = A_AND; end
        FN_OR:   begin dec_o.kind = K_ALU; dec_o.alu = A_OR;  end
        FN_XOR:  begin dec_o.kind = K_ALU; dec_o.alu = A_XOR; end
        FN_NOR:  begin dec_o.kind = K_ALU; dec_o.alu = A_NOR; end
        FN_SLT:  begin dec_o.kind = K_ALU; dec_o.alu = A_SLT; end
        FN_SLTU: begin dec_o.kind = K_ALU; dec_o.alu = A_SLTU; end
        default:  dec_o.kind = K_BAD;  // strict allow-list: no catch-all no-op
      endcase
    end
  end
endmodule

// File: rtl/sretire_alu.sv
module sretire_alu
  import sretire_pkg::*;
#(
  parameter int W = XLEN
) (
  input  alu_e         op_i,
  input  logic         var_shift_i,
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  logic [4:0]   shamt_i,
  output logic [W-1:0] res_o
);
  logic [4:0] sh;
  assign sh = var_shift_i ? a_i[4:0] : shamt_i;

  always_comb begin
    unique case (op_i)
      A_SLL:   res_o = b_i << sh;
      A_SRL:   res_o = b_i >> sh;
      A_SRA:   res_o = W'($signed(b_i) >>> sh);
      A_ADD:   res_o = a_i + b_i;
      A_SUB:   res_o = a_i - b_i;
      A_AND:   res_o = a_i & b_i;
      A_OR:    res_o = a_i | b_i;
      A_XOR:   res_o = a_i ^ b_i;
      A_NOR:   res_o = ~(a_i | b_i);
      A_SLT:   res_o = W'($signed(a_i) < $signed(b_i));
      A_SLTU:  res_o = W'(a_i < b_i);
      default: res_o = '0;
    endcase
  end
endmodule

// File: rtl/sretire_gprs.sv
module sretire_gprs
  import sretire_pkg::*;
#(
  parameter int N  = NREG,
  parameter int W  = XLEN,
  parameter int AW = $clog2(N)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          we_i,
  input  logic [AW-1:0] waddr_i,
  input  logic [W-1:0]  wdata_i,
  input  logic [AW-1:0] ra_a_i,
  output logic [W-1:0]  rd_a_o,
  input  logic [AW-1:0] ra_b_i,
  output logic [W-1:0]  rd_b_o,
  input  logic [AW-1:0] ra_c_i,
  output logic [W-1:0]  rd_c_o
);
  logic [W-1:0] mem [N];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < N; i++) mem[i] <= '0;
    end else if (we_i && waddr_i != '0) begin
      mem[waddr_i] <= wdata_i;
    end
  end

  assign rd_a_o = mem[ra_a_i];
  assign rd_b_o = mem[ra_b_i];
  assign rd_c_o = mem[ra_c_i];

  // R11
  reg_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni) mem[0] == '0);
  // R11
  reg_zero_write_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && waddr_i == '0) |=> mem[0] == '0);
endmodule

// File: rtl/sretire_core.sv
module sretire_core
  import sretire_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              strict_i,
  input  logic              valid_i,
  input  logic [XLEN-1:0]   instr_i,
  input  logic [XLEN-1:0]   pc_i,
  input  logic [RIDX_W-1:0] dbg_addr_i,
  output logic [XLEN-1:0]   dbg_data_o,
  output logic [XLEN-1:0]   hi_o,
  output logic [XLEN-1:0]   lo_o,
  output logic              retire_o,
  output logic [XLEN-1:0]   retire_pc_o,
  output logic [XLEN-1:0]   next_pc_o,
  output logic [CNT_W-1:0]  retire_cnt_o,
  output logic              trap_o,
  output logic [XLEN-1:0]   trap_pc_o,
  output logic [XLEN-1:0]   trap_instr_o
);
  localparam int W = XLEN;

  logic [5:0]        op, fn;
  logic [RIDX_W-1:0] rs_idx, rt_idx, rd_idx;
  logic [4:0]        shamt;
  logic [15:0]       imm;
  assign op     = instr_i[31:26];
  assign rs_idx = instr_i[25:21];
  assign rt_idx = instr_i[20:16];
  assign rd_idx = instr_i[15:11];
  assign shamt  = instr_i[10:6];
  assign fn     = instr_i[5:0];
  assign imm    = instr_i[15:0];

  dec_t dec;
  sretire_decode u_dec (.op_i(op), .fn_i(fn), .dec_o(dec));

  logic [W-1:0] rs_val, rt_val, alu_res;
  logic              gpr_we, wr_en;
  logic [RIDX_W-1:0] wr_idx;
  logic [W-1:0]      wr_val;

  sretire_gprs #(.N(NREG), .W(W), .AW(RIDX_W)) u_gprs (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .we_i(gpr_we), .waddr_i(wr_idx), .wdata_i(wr_val),
    .ra_a_i(rs_idx), .rd_a_o(rs_val),
    .ra_b_i(rt_idx), .rd_b_o(rt_val),
    .ra_c_i(dbg_addr_i), .rd_c_o(dbg_data_o)
  );

  sretire_alu #(.W(W)) u_alu (
    .op_i(dec.alu), .var_shift_i(dec.var_shift),
    .a_i(rs_val), .b_i(rt_val), .shamt_i(shamt), .res_o(alu_res)
  );

  logic trap_q, retire_q;
  logic accept, is_bad, fire, trap_hit;
  assign accept   = valid_i && !trap_q;
  assign is_bad   = (dec.kind == K_BAD);
  assign fire     = accept && !(is_bad && strict_i);
  assign trap_hit = accept && is_bad && strict_i;
  assign gpr_we   = fire && wr_en;

  logic [2*W-1:0] prod_s, prod_u;
  assign prod_s = $signed({{W{rs_val[W-1]}}, rs_val}) * $signed({{W{rt_val[W-1]}}, rt_val});
  assign prod_u = {{W{1'b0}}, rs_val} * {{W{1'b0}}, rt_val};

  logic [W-1:0] hi_q, lo_q, hi_n, lo_n, npc;
  logic         hilo_we;

  always_comb begin
    wr_en   = 1'b0;
    wr_idx  = rd_idx;
    wr_val  = '0;
    npc     = pc_i + W'(4);
    hilo_we = 1'b0;
    hi_n    = hi_q;
    lo_n    = lo_q;
    unique case (dec.kind)
      K_ALU:   begin wr_en = 1'b1; wr_val = alu_res; end
      K_LUI:   begin wr_en = 1'b1; wr_idx = rt_idx; wr_val = {imm, 16'h0}; end
      K_ORI:   begin wr_en = 1'b1; wr_idx = rt_idx; wr_val = rs_val | {16'h0, imm}; end
      K_JR:    npc = rs_val;
      K_JALR:  begin npc = rs_val; wr_en = 1'b1; wr_val = pc_i + W'(8); end
      K_SVC:   begin wr_en = 1'b1; wr_idx = SVC_RET_REG; wr_val = '0; end
      K_MFHI:  begin wr_en = 1'b1; wr_val = hi_q; end
      K_MFLO:  begin wr_en = 1'b1; wr_val = lo_q; end
      K_MTHI:  begin hilo_we = 1'b1; hi_n = rs_val; end
      K_MTLO:  begin hilo_we = 1'b1; lo_n = rs_val; end
      K_MULT:  begin hilo_we = 1'b1; {hi_n, lo_n} = prod_s; end
      K_MULTU: begin hilo_we = 1'b1; {hi_n, lo_n} = prod_u; end
      default: ;  // K_SYNC, K_NOP, K_BAD: side-effect free
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      retire_q     <= 1'b0;
      retire_pc_o  <= '0;
      next_pc_o    <= '0;
      retire_cnt_o <= '0;
      hi_q         <= '0;
      lo_q         <= '0;
      trap_q       <= 1'b0;
      trap_pc_o    <= '0;
      trap_instr_o <= '0;
    end else begin
      retire_q <= fire;
      if (fire) begin
        retire_pc_o  <= pc_i;
        next_pc_o    <= npc;
        retire_cnt_o <= retire_cnt_o + 1'b1;
        if (hilo_we) begin
          hi_q <= hi_n;
          lo_q <= lo_n;
        end
      end
      if (trap_hit) begin
        trap_q       <= 1'b1;
        trap_pc_o    <= pc_i;
        trap_instr_o <= instr_i;
      end
    end
  end

  assign retire_o = retire_q;
  assign trap_o   = trap_q;
  assign hi_o     = hi_q;
  assign lo_o     = lo_q;

  // R2
  sync_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fire && dec.kind == K_SYNC) |=> ($stable(hi_q) && $stable(lo_q) && next_pc_o == $past(pc_i) + W'(4)));
  // R2
  sync_no_gpr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fire && dec.kind == K_SYNC) |-> !gpr_we);
  // R8
  trap_capture_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(trap_q) |-> (trap_instr_o == $past(instr_i) && trap_pc_o == $past(pc_i)));
  // R10
  trap_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni) trap_q |=> trap_q);
  // R10
  trap_no_retire_chk: assert property (@(posedge clk_i) disable iff (!rst_ni) trap_q |-> !retire_q);
  // R12
  retire_cause_chk: assert property (@(posedge clk_i) disable iff (!rst_ni) retire_q |-> $past(valid_i));
  // R12
  retire_count_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    retire_q |-> retire_cnt_o == $past(retire_cnt_o) + 1'b1);
  // R12
  count_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !retire_q |-> $stable(retire_cnt_o));
endmodule

// File: tb/sretire_core_bench.sv
`timescale 1ns/1ps
module sretire_core_bench;
  localparam int CNT_W = 16;

  logic clk = 1'b0;
  always #2 clk = ~clk;  // 250 MHz

  logic              rst_ni, strict_i, valid_i;
  logic [31:0]       instr_i, pc_i;
  logic [4:0]        dbg_addr_i;
  logic [31:0]       dbg_data_o, hi_o, lo_o, retire_pc_o, next_pc_o, trap_pc_o, trap_instr_o;
  logic              retire_o, trap_o;
  logic [CNT_W-1:0]  retire_cnt_o;

  sretire_core #(.CNT_W(CNT_W)) u_sretire_core (
    .clk_i(clk), .rst_ni(rst_ni), .strict_i(strict_i), .valid_i(valid_i),
    .instr_i(instr_i), .pc_i(pc_i), .dbg_addr_i(dbg_addr_i), .dbg_data_o(dbg_data_o),
    .hi_o(hi_o), .lo_o(lo_o), .retire_o(retire_o), .retire_pc_o(retire_pc_o),
    .next_pc_o(next_pc_o), .retire_cnt_o(retire_cnt_o), .trap_o(trap_o),
    .trap_pc_o(trap_pc_o), .trap_instr_o(trap_instr_o)
  );

  int n_cmp = 0, n_bad = 0;
  bit done = 0;

  logic [31:0] m_gpr [32];
  logic [31:0] m_hi, m_lo, m_rpc, m_npc, m_tpc, m_tinstr;
  logic [CNT_W-1:0] m_cnt;
  bit m_trap, m_fire;

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic model_reset();
    for (int i = 0; i < 32; i++) m_gpr[i] = '0;
    m_hi = '0; m_lo = '0; m_rpc = '0; m_npc = '0; m_tpc = '0; m_tinstr = '0;
    m_cnt = '0; m_trap = 0; m_fire = 0;
  endtask

  function automatic bit known(logic [31:0] w);
    logic [5:0] f;
    f = w[5:0];
    if (w[31:26] == 6'h0F || w[31:26] == 6'h0D) return 1;
    if (w[31:26] != 6'h00) return 0;
    return f inside {6'h00, 6'h02, 6'h03, 6'h04, 6'h06, 6'h07, 6'h08, 6'h09, 6'h0C, 6'h0F,
                     6'h10, 6'h11, 6'h12, 6'h13, 6'h18, 6'h19, 6'h20, 6'h21, 6'h22, 6'h23,
                     6'h24, 6'h25, 6'h26, 6'h27, 6'h2A, 6'h2B};
  endfunction

  task automatic model_step(logic [31:0] w, logic [31:0] pc, bit strict);
    logic [31:0] a, b, v, npc;
    logic [63:0] p;
    int widx;
    bit wen;
    a = m_gpr[w[25:21]]; b = m_gpr[w[20:16]];
    npc = pc + 4; wen = 0; widx = w[15:11]; v = '0;
    m_fire = 0;
    if (m_trap) return;
    if (!known(w)) begin
      if (strict) begin m_trap = 1; m_tpc = pc; m_tinstr = w; return; end
    end else if (w[31:26] == 6'h0F) begin
      wen = 1; widx = w[20:16]; v = {w[15:0], 16'h0};
    end else if (w[31:26] == 6'h0D) begin
      wen = 1; widx = w[20:16]; v = a | {16'h0, w[15:0]};
    end else begin
      case (w[5:0])
        6'h00: begin wen = 1; v = b << w[10:6]; end
        6'h02: begin wen = 1; v = b >> w[10:6]; end
        6'h03: begin wen = 1; v = $signed(b) >>> w[10:6]; end
        6'h04: begin wen = 1; v = b << a[4:0]; end
        6'h06: begin wen = 1; v = b >> a[4:0]; end
        6'h07: begin wen = 1; v = $signed(b) >>> a[4:0]; end
        6'h08: npc = a;
        6'h09: begin npc = a; wen = 1; v = pc + 8; end
        6'h0C: begin wen = 1; widx = 2; v = 0; end
        6'h10: begin wen = 1; v = m_hi; end
        6'h12: begin wen = 1; v = m_lo; end
        6'h11: m_hi = a;
        6'h13: m_lo = a;
        6'h18: begin p = $signed({{32{a[31]}}, a}) * $signed({{32{b[31]}}, b}); {m_hi, m_lo} = p; end
        6'h19: begin p = {32'h0, a} * {32'h0, b}; {m_hi, m_lo} = p; end
        6'h20, 6'h21: begin wen = 1; v = a + b; end
        6'h22, 6'h23: begin wen = 1; v = a - b; end
        6'h24: begin wen = 1; v = a & b; end
        6'h25: begin wen = 1; v = a | b; end
        6'h26: begin wen = 1; v = a ^ b; end
        6'h27: begin wen = 1; v = ~(a | b); end
        6'h2A: begin wen = 1; v = ($signed(a) < $signed(b)) ? 32'd1 : 32'd0; end
        6'h2B: begin wen = 1; v = (a < b) ? 32'd1 : 32'd0; end
        default: ;
      endcase
    end
    if (wen && widx != 0) m_gpr[widx] = v;
    m_fire = 1; m_rpc = pc; m_npc = npc; m_cnt = m_cnt + 1'b1;
  endtask

  task automatic sweep(string req);
    int mism = 0;
    logic [31:0] first_act = '0, first_exp = '0;
    for (int i = 0; i < 32; i++) begin
      dbg_addr_i = 5'(i);
      #0.01;
      if (dbg_data_o !== m_gpr[i] && mism++ == 0) begin first_act = dbg_data_o; first_exp = m_gpr[i]; end
    end
    chk({req, " gpr sweep"}, first_act, first_exp);
  endtask

  task automatic check_state(string req);
    chk({req, " retire_o"}, 32'(retire_o), 32'(m_fire));
    chk({req, " trap_o"}, 32'(trap_o), 32'(m_trap));
    chk("R12 retire_cnt", 32'(retire_cnt_o), 32'(m_cnt));
    if (m_fire) begin
      chk("R12 retire_pc", retire_pc_o, m_rpc);
      chk({req, " next_pc"}, next_pc_o, m_npc);
    end
    if (m_trap) begin
      chk("R8 trap_pc", trap_pc_o, m_tpc);
      chk("R8 trap_instr", trap_instr_o, m_tinstr);
    end
    chk({req, " hi"}, hi_o, m_hi);
    chk({req, " lo"}, lo_o, m_lo);
    sweep(req);
  endtask

  task automatic issue(logic [31:0] w, logic [31:0] pc, string req);
    @(negedge clk);
    valid_i = 1; instr_i = w; pc_i = pc;
    model_step(w, pc, strict_i);
    @(negedge clk);
    valid_i = 0;
    check_state(req);
  endtask

  function automatic logic [31:0] rtype(int rs, int rt, int rd, int sh, logic [5:0] f);
    return {6'h00, 5'(rs), 5'(rt), 5'(rd), 5'(sh), f};
  endfunction
  function automatic logic [31:0] itype(logic [5:0] op, int rs, int rt, logic [15:0] imm);
    return {op, 5'(rs), 5'(rt), imm};
  endfunction

  task automatic do_reset();
    rst_ni = 0; valid_i = 0;
    #7;
    rst_ni = 1;
    model_reset();
    @(negedge clk);
  endtask

  logic [5:0] fn_pool [26] = '{6'h00, 6'h02, 6'h03, 6'h04, 6'h06, 6'h07, 6'h08, 6'h09, 6'h0C,
    6'h0F, 6'h10, 6'h11, 6'h12, 6'h13, 6'h18, 6'h19, 6'h20, 6'h21, 6'h22, 6'h23, 6'h24,
    6'h25, 6'h26, 6'h27, 6'h2A, 6'h2B};

  initial begin
    #(4 * 150000);
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4242));
    strict_i = 1; instr_i = '0; pc_i = '0; dbg_addr_i = '0;
    do_reset();
    // R1 reset state
    check_state("R1");

    // R4 fill registers via LUI/ORI
    for (int r = 1; r < 32; r++) begin
      issue(itype(6'h0F, 0, r, 16'($urandom)), 32'h1000 + 8 * r, "R4 lui");
      issue(itype(6'h0D, r, r, 16'($urandom)), 32'h1004 + 8 * r, "R4 ori");
    end

    // R5 HI/LO setup, then R2 barrier
    issue(rtype(3, 0, 0, 0, 6'h11), 32'h0F0, "R5 mthi");
    issue(rtype(4, 0, 0, 0, 6'h13), 32'h0F4, "R5 mtlo");
    issue(32'h0000000F, 32'h100, "R2 sync");
    @(negedge clk);
    chk("R12 pulse width", 32'(retire_o), 32'h0);
    // R4 LUI+ORI right after the barrier
    issue(itype(6'h0F, 0, 9, 16'hCAFE), 32'h104, "R4 post-sync lui");
    issue(itype(6'h0D, 9, 9, 16'h1234), 32'h108, "R4 post-sync ori");
    chk("R4 r9 value", m_gpr[9], 32'hCAFE1234);

    // R11 write to r0
    issue(itype(6'h0D, 5, 0, 16'hFFFF), 32'h10C, "R11 ori r0");
    issue(rtype(5, 6, 0, 0, 6'h21), 32'h110, "R11 addu r0");

    // R6 jumps
    issue(rtype(9, 0, 0, 0, 6'h08), 32'h114, "R6 jr");
    issue(rtype(9, 0, 31, 0, 6'h09), 32'h118, "R6 jalr");
    // R7 service call
    issue(32'h0000000C, 32'h11C, "R7 syscall");
    // R3 shift corner: arithmetic right of negative by 31
    issue(itype(6'h0F, 0, 12, 16'h8000), 32'h120, "R4 lui");
    issue(rtype(0, 12, 13, 31, 6'h03), 32'h124, "R3 sra 31");
    issue(rtype(12, 1, 14, 0, 6'h2A), 32'h128, "R3 slt neg");
    issue(rtype(12, 1, 15, 0, 6'h2B), 32'h12C, "R3 sltu");
    issue(rtype(12, 12, 16, 0, 6'h18), 32'h130, "R5 mult");
    issue(rtype(12, 12, 16, 0, 6'h19), 32'h134, "R5 multu");
    issue(rtype(0, 0, 17, 0, 6'h10), 32'h138, "R5 mfhi");
    issue(rtype(0, 0, 18, 0, 6'h12), 32'h13C, "R5 mflo");

    // constrained random legal traffic (R3 R5 R6 R7 R2)
    for (int n = 0; n < 400; n++) begin
      logic [31:0] w;
      int k = $urandom_range(0, 27);
      if (k == 26)      w = itype(6'h0F, $urandom_range(0, 31), $urandom_range(0, 31), 16'($urandom));
      else if (k == 27) w = itype(6'h0D, $urandom_range(0, 31), $urandom_range(0, 31), 16'($urandom));
      else w = rtype($urandom_range(0, 31), $urandom_range(0, 31), $urandom_range(0, 31),
                     $urandom_range(0, 31), fn_pool[k]);
      issue(w, {$urandom_range(0, 32'h3FFF_FFFF), 2'b00}, "R3 random");
    end

    // R9 relaxed mode: neighbour of the barrier and a load opcode retire as no-ops
    strict_i = 0;
    issue(32'h0000000E, 32'h200, "R9 funct 0x0E relaxed");
    issue(itype(6'h23, 1, 2, 16'h0010), 32'h204, "R9 opcode 0x23 relaxed");

    // R8 strict mode trap on 0x0000000E
    strict_i = 1;
    issue(32'h0000000E, 32'h300, "R8 funct 0x0E strict");
    chk("R8 trap raised", 32'(trap_o), 32'h1);
    // R10 further input ignored
    issue(32'h0000000F, 32'h304, "R10 sync after trap");
    issue(itype(6'h0F, 0, 7, 16'hBEEF), 32'h308, "R10 lui after trap");
    @(negedge clk);
    chk("R10 trap held", 32'(trap_o), 32'h1);

    // R1 reset clears trap
    do_reset();
    check_state("R1 after trap");
    // R8 other primary opcode traps too
    issue(itype(6'h2B, 1, 2, 16'h0), 32'h400, "R8 opcode 0x2B strict");
    @(negedge clk);
    chk("R10 trap held 2", 32'(trap_o), 32'h1);

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule